// File: doc/BRIEF.md
# Shared Cycle Counter with Per-Context Compare Timers

This block keeps one free-running cycle counter that all processor contexts share. Each context owns a compare value, and the block raises that context's timer interrupt once the shared count has reached the compare value. Software reaches every register over a 32-bit register bus. The counter and the compare values are wider than the bus, so each one is read and written as a low half and a high half at two word addresses. The counter width is a build parameter. It is `32 + 4 × CNT_FIELD` bits, and the field value can be read back from the configuration word. A reader gets a consistent wide value by reading high, then low, then high again, and reading again if the two high values differ.

Each access carries the index of the context that issues it. The local window addresses the issuing context's own compare registers and mask. Each context also holds a peer selector. The other-context window uses that selector to address a different context's compare registers and mask, so one context can program a timer for another.

The counter runs under a two-state machine. In CNT_RUNNING it counts, and a configuration write with bit 0 set moves it to CNT_STOPPED. In CNT_STOPPED it holds, and a configuration write with bit 0 clear moves it back to CNT_RUNNING. Each context slot has its own two-state machine. SLOT_ARMED moves to SLOT_FIRED when count ≥ compare and no compare write takes place in that cycle. SLOT_FIRED moves back to SLOT_ARMED on any write to either compare half.

Top module: `shcnt_timer`

Word map on `bus_addr_i`:
- Counter and configuration: 0 = configuration, 1 = counter low, 2 = counter high.
- Local window: 4 = compare low, 5 = compare high, 6 = mask set, 7 = mask clear, 8 = status, 9 = peer selector.
- Other-context window: 12 = compare low, 13 = compare high, 14 = mask set, 15 = mask clear, 16 = status.

## Requirements
- R1: After reset the counter is zero and running, every compare value is all ones within the counter width, every timer is masked and idle (`irq_o` = 0, status word 0), and every peer selector is 0.
- R2: The configuration word (word 0) reads bit 0 = 1 while the counter is stopped and bits [11:8] = CNT_FIELD; all other bits read 0. A write to word 0 stops the counter when bit 0 is 1 and starts it when bit 0 is 0.
- R3: While running, the counter grows by exactly one per clock. While stopped and not loaded, it holds its value.
- R4: Word 1 returns count bits [31:0] and word 2 returns bits [63:32] of the current count. A carry from the low half shows in the high half on the same edge, so a high-low-high read that straddles the carry sees two different high values.
- R5: A write to word 1 or word 2 loads that half of the counter in place of counting on that edge. Bits at and above the width are dropped and read as 0. The counter wraps to zero at 2^width.
- R6: Compare halves are written and read at words 4 and 5 (local) and words 12 and 13 (other). Bits above the width read as 0.
- R7: A context's slot fires when count ≥ compare. `irq_o[c]` is high when slot c has fired and is unmasked.
- R8: A write to either compare half of a context returns its slot to armed on that edge. The slot fires again on the next edge if count ≥ compare still holds. Otherwise the slot stays fired until such a write.
- R9: A mask-set write with bit 0 = 1 unmasks the context. A mask-clear write with bit 0 = 1 masks it. Either write with bit 0 = 0 changes nothing. The status word reads bit 0 = unmasked and bit 1 = fired.
- R10: Word 9 holds the issuing context's peer selector. Words 12 to 16 act on the context named by the issuing context's selector and leave the issuing context's own registers untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe for the current word |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_ctx_i | input | CTX_W | Index of the issuing context |
| bus_rdata_o | output | 32 | Read data for the current word and context (combinational) |
| irq_o | output | NUM_CTX | One timer interrupt per context |

## Verification
The hardest case to reach from the ports is a split read in which the low half carries into the high half between the two half reads. This is the torn read that the high-low-high protocol has to detect. The bench stops the counter, loads it two counts below a carry, and restarts it. It then reads high, low and high on three consecutive cycles, so the carry lands on a known edge and every value is known exactly. The same approach sets up the wrap at full width, on a full-width instance and on a narrower one, side by side.

// File: rtl/shcnt_pkg.sv
package shcnt_pkg;

    localparam int ADDR_W = 6;

    // word addresses on the register bus
    localparam logic [ADDR_W-1:0] W_CFG     = 6'd0;
    localparam logic [ADDR_W-1:0] W_CNT_LO  = 6'd1;
    localparam logic [ADDR_W-1:0] W_CNT_HI  = 6'd2;
    localparam logic [ADDR_W-1:0] W_CMP_LO  = 6'd4;
    localparam logic [ADDR_W-1:0] W_CMP_HI  = 6'd5;
    localparam logic [ADDR_W-1:0] W_MSET    = 6'd6;
    localparam logic [ADDR_W-1:0] W_MCLR    = 6'd7;
    localparam logic [ADDR_W-1:0] W_STAT    = 6'd8;
    localparam logic [ADDR_W-1:0] W_PSEL    = 6'd9;
    localparam logic [ADDR_W-1:0] W_OCMP_LO = 6'd12;
    localparam logic [ADDR_W-1:0] W_OCMP_HI = 6'd13;
    localparam logic [ADDR_W-1:0] W_OMSET   = 6'd14;
    localparam logic [ADDR_W-1:0] W_OMCLR   = 6'd15;
    localparam logic [ADDR_W-1:0] W_OSTAT   = 6'd16;

    typedef enum logic {
        CNT_RUNNING = 1'b0,
        CNT_STOPPED = 1'b1
    } run_state_e;

    typedef enum logic {
        SLOT_ARMED = 1'b0,
        SLOT_FIRED = 1'b1
    } slot_state_e;

    function automatic int width_of(input int field);
        return 32 + 4 * field;
    endfunction

endpackage

// File: rtl/shcnt_count.sv
module shcnt_count
    import shcnt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic             ld_lo_i,
    input  logic             ld_hi_i,
    input  logic [31:0]      wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             halted_o
);

    run_state_e       st_q, st_d;
    logic             step;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [63:0]      ld_ext;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= CNT_RUNNING;
        else         st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CNT_RUNNING: if (cfg_wr_i && wdata_i[0])  st_d = CNT_STOPPED;
            CNT_STOPPED: if (cfg_wr_i && !wdata_i[0]) st_d = CNT_RUNNING;
            default:     st_d = CNT_RUNNING;
        endcase
    end

    // state outputs
    always_comb begin
        step     = 1'b0;
        halted_o = 1'b0;
        unique case (st_q)
            CNT_RUNNING: step     = 1'b1;
            CNT_STOPPED: halted_o = 1'b1;
            default:     step     = 1'b0;
        endcase
    end

    // a load replaces the increment on its edge
    always_comb begin
        ld_ext = 64'(cnt_q);
        if (ld_lo_i) ld_ext[31:0]  = wdata_i;
        if (ld_hi_i) ld_ext[63:32] = wdata_i;
        if (ld_lo_i || ld_hi_i) cnt_d = ld_ext[CNT_W-1:0];
        else if (step)          cnt_d = cnt_q + CNT_W'(1);
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/shcnt_slot.sv
module shcnt_slot
    import shcnt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic             mset_i,
    input  logic             mclr_i,
    input  logic [31:0]      wdata_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             fired_o,
    output logic             en_o,
    output logic             irq_o
);

    slot_state_e      st_q, st_d;
    logic [CNT_W-1:0] cmp_q;
    logic [63:0]      cmp_ext;
    logic             en_q;
    logic             cmp_wr;
    logic             hit;

    assign cmp_wr = wr_lo_i || wr_hi_i;
    assign hit    = cnt_i >= cmp_q;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= SLOT_ARMED;
        else         st_q <= st_d;
    end

    // transitions: a compare write always re-arms
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_ARMED: if (!cmp_wr && hit) st_d = SLOT_FIRED;
            SLOT_FIRED: if (cmp_wr)         st_d = SLOT_ARMED;
            default:    st_d = SLOT_ARMED;
        endcase
    end

    // state outputs
    always_comb begin
        fired_o = 1'b0;
        unique case (st_q)
            SLOT_ARMED: fired_o = 1'b0;
            SLOT_FIRED: fired_o = 1'b1;
            default:    fired_o = 1'b0;
        endcase
        irq_o = fired_o && en_q;
    end

    // compare halves
    always_comb begin
        cmp_ext = 64'(cmp_q);
        if (wr_lo_i) cmp_ext[31:0]  = wdata_i;
        if (wr_hi_i) cmp_ext[63:32] = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cmp_q <= '1;
            en_q  <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q <= cmp_ext[CNT_W-1:0];
            if (mset_i && wdata_i[0])      en_q <= 1'b1;
            else if (mclr_i && wdata_i[0]) en_q <= 1'b0;
        end
    end

    assign cmp_o = cmp_q;
    assign en_o  = en_q;

endmodule

// File: rtl/shcnt_timer.sv
module shcnt_timer
    import shcnt_pkg::*;
#(
    parameter  int NUM_CTX   = 4,
    parameter  int CNT_FIELD = 8,
    localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    input  logic [CTX_W-1:0]   bus_ctx_i,
    output logic [31:0]        bus_rdata_o,
    output logic [NUM_CTX-1:0] irq_o
);

    localparam int CNT_W = width_of(CNT_FIELD);

    logic [CNT_W-1:0]         cnt;
    logic                     halted;
    logic                     ld_lo, ld_hi, ld_any, cfg_wr;
    logic [CNT_W-1:0]         cmp_arr [NUM_CTX];
    logic [CTX_W-1:0]         psel_q  [NUM_CTX];
    logic [NUM_CTX*CNT_W-1:0] cmp_flat;
    logic [NUM_CTX-1:0]       cmp_wr_vec, fired_vec, en_vec;
    logic [CTX_W-1:0]         oth;

    assign cfg_wr = bus_wr_i && (bus_addr_i == W_CFG);
    assign ld_lo  = bus_wr_i && (bus_addr_i == W_CNT_LO);
    assign ld_hi  = bus_wr_i && (bus_addr_i == W_CNT_HI);
    assign ld_any = ld_lo || ld_hi;
    assign oth    = psel_q[bus_ctx_i];

    shcnt_count #(.CNT_W(CNT_W)) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cfg_wr_i (cfg_wr),
        .ld_lo_i  (ld_lo),
        .ld_hi_i  (ld_hi),
        .wdata_i  (bus_wdata_i),
        .cnt_o    (cnt),
        .halted_o (halted)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        logic             loc_hit, oth_hit;
        logic             wr_lo, wr_hi, mset, mclr;
        logic [CTX_W-1:0] psel_r;

        assign loc_hit = bus_ctx_i == CTX_W'(c);
        assign oth_hit = oth == CTX_W'(c);
        assign wr_lo   = bus_wr_i && ((bus_addr_i == W_CMP_LO  && loc_hit) ||
                                      (bus_addr_i == W_OCMP_LO && oth_hit));
        assign wr_hi   = bus_wr_i && ((bus_addr_i == W_CMP_HI  && loc_hit) ||
                                      (bus_addr_i == W_OCMP_HI && oth_hit));
        assign mset    = bus_wr_i && ((bus_addr_i == W_MSET  && loc_hit) ||
                                      (bus_addr_i == W_OMSET && oth_hit));
        assign mclr    = bus_wr_i && ((bus_addr_i == W_MCLR  && loc_hit) ||
                                      (bus_addr_i == W_OMCLR && oth_hit));

        shcnt_slot #(.CNT_W(CNT_W)) u_slot (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .cnt_i   (cnt),
            .wr_lo_i (wr_lo),
            .wr_hi_i (wr_hi),
            .mset_i  (mset),
            .mclr_i  (mclr),
            .wdata_i (bus_wdata_i),
            .cmp_o   (cmp_arr[c]),
            .fired_o (fired_vec[c]),
            .en_o    (en_vec[c]),
            .irq_o   (irq_o[c])
        );

        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                psel_r <= '0;
            else if (bus_wr_i && bus_addr_i == W_PSEL && loc_hit)
                psel_r <= bus_wdata_i[CTX_W-1:0];
        end

        assign psel_q[c]                   = psel_r;
        assign cmp_wr_vec[c]               = wr_lo || wr_hi;
        assign cmp_flat[c*CNT_W +: CNT_W]  = cmp_arr[c];
    end

    // read mux
    logic [63:0] cnt_ext, loc_ext, oth_ext;

    always_comb begin
        cnt_ext     = 64'(cnt);
        loc_ext     = 64'(cmp_arr[bus_ctx_i]);
        oth_ext     = 64'(cmp_arr[oth]);
        bus_rdata_o = '0;
        case (bus_addr_i)
            W_CFG:     bus_rdata_o = {20'd0, 4'(CNT_FIELD), 7'd0, halted};
            W_CNT_LO:  bus_rdata_o = cnt_ext[31:0];
            W_CNT_HI:  bus_rdata_o = cnt_ext[63:32];
            W_CMP_LO:  bus_rdata_o = loc_ext[31:0];
            W_CMP_HI:  bus_rdata_o = loc_ext[63:32];
            W_STAT:    bus_rdata_o = {30'd0, fired_vec[bus_ctx_i], en_vec[bus_ctx_i]};
            W_PSEL:    bus_rdata_o = 32'(psel_q[bus_ctx_i]);
            W_OCMP_LO: bus_rdata_o = oth_ext[31:0];
            W_OCMP_HI: bus_rdata_o = oth_ext[63:32];
            W_OSTAT:   bus_rdata_o = {30'd0, fired_vec[oth], en_vec[oth]};
            default:   bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/shcnt_timer_chk.sv
module shcnt_timer_chk #(
    parameter int NUM_CTX = 4,
    parameter int CNT_W   = 64
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     halted,
    input logic                     ld_any,
    input logic [CNT_W-1:0]         cnt,
    input logic [NUM_CTX*CNT_W-1:0] cmp_flat,
    input logic [NUM_CTX-1:0]       cmp_wr_vec,
    input logic [NUM_CTX-1:0]       fired_vec
);

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halted && !ld_any) |=> $stable(cnt)); // R3

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halted && !ld_any) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R3

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
        AST_FIRE_ON_REACH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((cnt >= cmp_flat[c*CNT_W +: CNT_W]) && !cmp_wr_vec[c]) |=> fired_vec[c]); // R7

        AST_WRITE_REARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cmp_wr_vec[c] |=> !fired_vec[c]); // R8

        AST_FIRED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fired_vec[c] && !cmp_wr_vec[c]) |=> fired_vec[c]); // R8
    end

endmodule

bind shcnt_timer shcnt_timer_chk #(.NUM_CTX(NUM_CTX), .CNT_W(CNT_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halted     (halted),
    .ld_any     (ld_any),
    .cnt        (cnt),
    .cmp_flat   (cmp_flat),
    .cmp_wr_vec (cmp_wr_vec),
    .fired_vec  (fired_vec)
);

// File: tb/shcnt_timer_tb_top.sv
`timescale 1ns/1ps
module shcnt_timer_tb_top;
    import shcnt_pkg::*;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_IRQ = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  ctx;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // counter stopped throughout, so every value is fixed
    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{OP_WR,  2'd0, W_CFG,     32'h1,        32'h0,        4'd2},  // R2 stop
        '{OP_WR,  2'd0, W_CNT_LO,  32'h100,      32'h0,        4'd5},  // R5 load
        '{OP_WR,  2'd0, W_CNT_HI,  32'h2,        32'h0,        4'd5},
        '{OP_RD,  2'd0, W_CNT_LO,  32'h0,        32'h100,      4'd5},
        '{OP_RD,  2'd0, W_CNT_HI,  32'h0,        32'h2,        4'd5},
        '{OP_RD,  2'd0, W_CFG,     32'h0,        32'h801,      4'd2},  // R2 field 8, stopped
        '{OP_RD,  2'd1, W_CMP_LO,  32'h0,        32'hFFFFFFFF, 4'd1},  // R1 compare reset
        '{OP_WR,  2'd1, W_CMP_HI,  32'h2,        32'h0,        4'd6},  // R6
        '{OP_WR,  2'd1, W_CMP_LO,  32'h200,      32'h0,        4'd6},
        '{OP_RD,  2'd1, W_CMP_HI,  32'h0,        32'h2,        4'd6},
        '{OP_WR,  2'd1, W_MSET,    32'h1,        32'h0,        4'd9},  // R9
        '{OP_IRQ, 2'd0, 6'd0,      32'h0,        32'h0,        4'd7},  // R7 below compare
        '{OP_WR,  2'd1, W_CMP_LO,  32'h100,      32'h0,        4'd7},  // equal
        '{OP_IRQ, 2'd0, 6'd0,      32'h0,        32'h2,        4'd7},
        '{OP_RD,  2'd1, W_STAT,    32'h0,        32'h3,        4'd9},
        '{OP_WR,  2'd1, W_MCLR,    32'h0,        32'h0,        4'd9},  // R9 bit0=0 ignored
        '{OP_RD,  2'd1, W_STAT,    32'h0,        32'h3,        4'd9},
        '{OP_WR,  2'd1, W_MCLR,    32'h1,        32'h0,        4'd9},
        '{OP_IRQ, 2'd0, 6'd0,      32'h0,        32'h0,        4'd9},
        '{OP_RD,  2'd1, W_STAT,    32'h0,        32'h2,        4'd9},
        '{OP_WR,  2'd1, W_MSET,    32'h1,        32'h0,        4'd9},
        '{OP_IRQ, 2'd0, 6'd0,      32'h0,        32'h2,        4'd7},
        '{OP_WR,  2'd1, W_CMP_HI,  32'h3,        32'h0,        4'd8},  // R8 rearm
        '{OP_IRQ, 2'd0, 6'd0,      32'h0,        32'h0,        4'd8},
        '{OP_RD,  2'd1, W_STAT,    32'h0,        32'h1,        4'd8},
        '{OP_WR,  2'd0, W_PSEL,    32'h2,        32'h0,        4'd10}, // R10 peer
        '{OP_WR,  2'd0, W_OCMP_LO, 32'h50,       32'h0,        4'd10},
        '{OP_WR,  2'd0, W_OCMP_HI, 32'h0,        32'h0,        4'd10},
        '{OP_WR,  2'd0, W_OMSET,   32'h1,        32'h0,        4'd10},
        '{OP_IRQ, 2'd0, 6'd0,      32'h0,        32'h4,        4'd10},
        '{OP_RD,  2'd2, W_CMP_LO,  32'h0,        32'h50,       4'd10},
        '{OP_RD,  2'd0, W_CMP_LO,  32'h0,        32'hFFFFFFFF, 4'd10},
        '{OP_RD,  2'd0, W_OSTAT,   32'h0,        32'h3,        4'd10},
        '{OP_RD,  2'd0, W_PSEL,    32'h0,        32'h2,        4'd10},
        '{OP_WR,  2'd2, W_CMP_LO,  32'h60,       32'h0,        4'd8},  // R8 refires
        '{OP_IRQ, 2'd0, 6'd0,      32'h0,        32'h4,        4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_ctx = '0;
    logic [31:0] rdata, rdata_w;
    logic [3:0]  irq;
    logic [1:0]  irq_w;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    shcnt_timer #(.NUM_CTX(4), .CNT_FIELD(8)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_ctx_i(bus_ctx), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // 40-bit instance sharing the bus
    shcnt_timer #(.NUM_CTX(2), .CNT_FIELD(2)) dut_w (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_ctx_i(bus_ctx[0]), .bus_rdata_o(rdata_w), .irq_o(irq_w)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] ctx, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_ctx = ctx; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] ctx, input logic [5:0] a,
                         output logic [31:0] v, output logic [31:0] vw);
        @(negedge clk);
        bus_ctx = ctx; bus_addr = a;
        #1;
        v = rdata; vw = rdata_w;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] a, b, aw, bw;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_rd(2'd0, W_CFG, a, aw);
        chk("R1 cfg running", a, 32'h800);
        chk("R2 narrow field", aw, 32'h200);
        chk("R1 irq idle", {28'd0, irq}, 32'h0);
        do_rd(2'd0, W_CNT_HI, a, aw);
        chk("R1 count high zero", a, 32'h0);
        do_rd(2'd0, W_STAT, a, aw);
        chk("R1 status masked idle", a, 32'h0);
        do_rd(2'd3, W_PSEL, a, aw);
        chk("R1 peer select zero", a, 32'h0);
        do_rd(2'd0, W_CMP_HI, a, aw);
        chk("R6 narrow compare high", aw, 32'hFF);

        // R3 step while running
        do_rd(2'd0, W_CNT_LO, a, aw);
        do_rd(2'd0, W_CNT_LO, b, bw);
        chk("R3 step one", b - a, 32'd1);
        repeat (9) @(negedge clk);
        do_rd(2'd0, W_CNT_LO, b, bw);
        chk("R3 step ten", b - a, 32'd11);

        // R3 hold while stopped
        do_wr(2'd0, W_CFG, 32'h1);
        do_rd(2'd0, W_CNT_LO, a, aw);
        repeat (5) @(negedge clk);
        do_rd(2'd0, W_CNT_LO, b, bw);
        chk("R3 hold", b, a);

        // table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            case (v.op)
                OP_WR: do_wr(v.ctx, v.addr, v.data);
                OP_RD: begin
                    do_rd(v.ctx, v.addr, a, aw);
                    chk($sformatf("R%0d vector %0d", v.req, i), a, v.exp);
                end
                default: begin
                    repeat (2) @(negedge clk);
                    chk($sformatf("R%0d vector %0d irq", v.req, i), {28'd0, irq}, v.exp);
                end
            endcase
        end

        // R4 carry between half reads (torn read)
        do_wr(2'd0, W_CNT_LO, 32'hFFFFFFFE);
        do_wr(2'd0, W_CNT_HI, 32'h5);
        do_wr(2'd0, W_CFG, 32'h0);
        do_rd(2'd0, W_CNT_HI, a, aw);
        chk("R4 high before carry", a, 32'h5);
        do_rd(2'd0, W_CNT_LO, a, aw);
        chk("R4 low after carry", a, 32'h0);
        do_rd(2'd0, W_CNT_HI, a, aw);
        chk("R4 high after carry", a, 32'h6);

        // R5 wrap at full and narrow width
        do_wr(2'd0, W_CFG, 32'h1);
        do_wr(2'd0, W_CNT_LO, 32'hFFFFFFFE);
        do_wr(2'd0, W_CNT_HI, 32'hFFFFFFFF);
        do_rd(2'd0, W_CNT_HI, a, aw);
        chk("R5 narrow drops high bits", aw, 32'hFF);
        do_wr(2'd0, W_CFG, 32'h0);
        do_rd(2'd0, W_CNT_HI, a, aw);
        chk("R5 full high before wrap", a, 32'hFFFFFFFF);
        chk("R5 narrow high before wrap", aw, 32'hFF);
        do_rd(2'd0, W_CNT_LO, a, aw);
        chk("R5 full low wrapped", a, 32'h0);
        chk("R5 narrow low wrapped", aw, 32'h0);
        do_rd(2'd0, W_CNT_HI, a, aw);
        chk("R5 full high wrapped", a, 32'h0);
        chk("R5 narrow high wrapped", aw, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule